// File: doc/BRIEF.md
# Multiplexed Queue Status Flag Bus

This block shows the almost-full and almost-empty status of up to 32 queues on two narrow buses. Each bus is eight bits wide and carries one flag type. Both flag types are active-low. The block does not compute the flags. It takes the per-queue flag vectors from the queue logic, picks a window of eight queues, and registers that window onto the buses. A group number goes out with the buses, so a receiver can tell which eight queues it is looking at.

The buses report queues that are not in use on a port. The queue that is currently selected for writing always reads inactive on the almost-full bus. The queue that is currently selected for reading always reads inactive on the almost-empty bus. Those two queues have their own dedicated flags elsewhere.

The mapping depends on the configured queue count:
- **Eight queues or fewer:** the buses are static, with one bit fixed to each queue.
- **More than eight queues:** the buses are time-shared across groups. In **polled** mode they rotate through the groups on their own. In **direct** mode an input chooses the group.

There is no data stream through the block. Every pin is a plain control or status signal with no handshake. The buses are updated on every clock.

Top module: `mqf_flag_bus`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, both buses read all ones and `grp_id` reads 0.
- R2: When the effective queue count is 8 or less, `grp_id` reads 0 after every clock edge, in either mode. Bus bit i then shows queue i.
- R3: After each rising clock edge, bit i of each bus equals the flag of queue `grp_id*8+i` as sampled at that edge. No queue other than that one can affect the bit.
- R4: With `mode_direct`=0 and more than 8 queues, `grp_id` advances by one each clock. When `grp_id` is at or beyond the last group that holds a configured queue, `grp_id` returns to 0 instead. Groups that hold no configured queue are skipped.
- R5: With `mode_direct`=1 and more than 8 queues, `grp_id` takes the value of `grp_sel` sampled at the previous edge. An unconfigured group may be selected.
- R6: A bus bit whose queue index is at or above the effective queue count reads 1 (inactive).
- R7: The almost-full bit of the queue named by `wr_qsel` reads 1. The almost-empty bit of the queue named by `rd_qsel` reads 1. Each exclusion uses the selects sampled at the same edge as the flags. Other bits are unaffected.
- R8: A `num_queues` value of 0 is treated as 1. A value above 32 is treated as 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| af_flags_n | input | 32 | Per-queue almost-full flags, active-low, bit q = queue q |
| ae_flags_n | input | 32 | Per-queue almost-empty flags, active-low, bit q = queue q |
| num_queues | input | 6 | Configured queue count (0 read as 1, above 32 read as 32) |
| mode_direct | input | 1 | 0 = polled rotation, 1 = direct group selection |
| grp_sel | input | 2 | Group chosen in direct mode |
| wr_qsel | input | 5 | Queue selected on the write port |
| rd_qsel | input | 5 | Queue selected on the read port |
| af_bus_n | output | 8 | Almost-full status of the shown group, active-low |
| ae_bus_n | output | 8 | Almost-empty status of the shown group, active-low |
| grp_id | output | 2 | Number of the group currently on the buses |

## Verification
Flags are randomised on every cycle. A group mix-up or a one-cycle skew between `grp_id` and the bus contents therefore shows up at once.

Each queue-count pattern separates a different kind of fault:
- **Counts of 5 and 8:** expose a group counter that moves when it must stay still.
- **Counts of 12, 20 and 32:** separate wrap-at-last-group from wrap-at-group-three. The count of 12 also leaves half a group unconfigured.
- **Counts of 0 and 40:** check the clamping.

Direct mode is driven with random selects, including groups beyond the configured range. A run with all flags asserted isolates the port exclusions, because only an excluded or unconfigured bit can then read 1.

// File: rtl/mqf_pkg.sv
package mqf_pkg;
  localparam int unsigned MQF_NQ_MAX = 32;
  localparam int unsigned MQF_BUS_W  = 8;
  localparam int unsigned MQF_NFLAG  = 2;   // almost-full, almost-empty
  localparam int unsigned MQF_AF     = 0;
  localparam int unsigned MQF_AE     = 1;

  typedef enum logic {
    MQF_POLLED = 1'b0,
    MQF_DIRECT = 1'b1
  } mqf_mode_e;
endpackage

// File: rtl/mqf_cfg_decode.sv
module mqf_cfg_decode #(
  parameter int unsigned NQ_MAX = 32,
  parameter int unsigned BUS_W  = 8,
  parameter int unsigned CW     = 6,
  parameter int unsigned GW     = 2
) (
  input  logic [CW-1:0] num_queues,
  output logic [CW-1:0] cfg_cnt,
  output logic [GW-1:0] last_grp,
  output logic          multi_grp
);
  localparam int unsigned LGB = $clog2(BUS_W);

  logic [CW-1:0] cnt_m1;

  // Clamp the programmed count into 1..NQ_MAX.
  always_comb begin
    if (num_queues == '0)
      cfg_cnt = CW'(1);
    else if (num_queues > CW'(NQ_MAX))
      cfg_cnt = CW'(NQ_MAX);
    else
      cfg_cnt = num_queues;
  end

  assign cnt_m1    = cfg_cnt - CW'(1);
  assign last_grp  = GW'(cnt_m1 >> LGB);
  assign multi_grp = (cfg_cnt > CW'(BUS_W));
endmodule

// File: rtl/mqf_grp_seq.sv
module mqf_grp_seq #(
  parameter int unsigned GW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_direct,
  input  logic [GW-1:0] grp_sel,
  input  logic          multi_grp,
  input  logic [GW-1:0] last_grp,
  output logic [GW-1:0] grp_nxt,
  output logic [GW-1:0] grp_q
);
  import mqf_pkg::*;

  mqf_mode_e mode;
  assign mode = mqf_mode_e'(mode_direct);

  always_comb begin
    if (!multi_grp) begin
      grp_nxt = '0;
    end else begin
      unique case (mode)
        MQF_DIRECT: grp_nxt = grp_sel;
        default:    grp_nxt = (grp_q >= last_grp) ? '0 : grp_q + GW'(1);
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) grp_q <= '0;
    else        grp_q <= grp_nxt;
  end
endmodule

// File: rtl/mqf_lane_mask.sv
module mqf_lane_mask #(
  parameter int unsigned NQ_MAX = 32,
  parameter int unsigned BUS_W  = 8,
  parameter int unsigned CW     = 6,
  parameter int unsigned GW     = 2,
  parameter int unsigned QW     = 5
) (
  input  logic [NQ_MAX-1:0] flags_n,
  input  logic [GW-1:0]     grp,
  input  logic [CW-1:0]     cfg_cnt,
  input  logic [QW-1:0]     excl_q,
  output logic [BUS_W-1:0]  bus_n
);
  localparam int unsigned IW = CW + GW + 1;

  for (genvar i = 0; i < BUS_W; i++) begin : g_bit
    logic [IW-1:0] qidx;
    logic          live;

    assign qidx = IW'(grp) * IW'(BUS_W) + IW'(i);
    assign live = (qidx < IW'(cfg_cnt)) && (qidx[QW-1:0] != excl_q);

    always_comb begin
      bus_n[i] = 1'b1;
      if (live) bus_n[i] = flags_n[qidx[QW-1:0]];
    end
  end
endmodule

// File: rtl/mqf_flag_bus.sv
module mqf_flag_bus #(
  parameter int unsigned NQ_MAX = mqf_pkg::MQF_NQ_MAX,
  parameter int unsigned BUS_W  = mqf_pkg::MQF_BUS_W,
  localparam int unsigned NGRP  = NQ_MAX / BUS_W,
  localparam int unsigned GW    = (NGRP > 1) ? $clog2(NGRP) : 1,
  localparam int unsigned CW    = $clog2(NQ_MAX + 1),
  localparam int unsigned QW    = $clog2(NQ_MAX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NQ_MAX-1:0] af_flags_n,
  input  logic [NQ_MAX-1:0] ae_flags_n,
  input  logic [CW-1:0]     num_queues,
  input  logic              mode_direct,
  input  logic [GW-1:0]     grp_sel,
  input  logic [QW-1:0]     wr_qsel,
  input  logic [QW-1:0]     rd_qsel,
  output logic [BUS_W-1:0]  af_bus_n,
  output logic [BUS_W-1:0]  ae_bus_n,
  output logic [GW-1:0]     grp_id
);
  import mqf_pkg::*;

  logic [CW-1:0] cfg_cnt;
  logic [GW-1:0] last_grp;
  logic          multi_grp;
  logic [GW-1:0] grp_nxt;

  logic [NQ_MAX-1:0] flg_in  [MQF_NFLAG];
  logic [QW-1:0]     excl_in [MQF_NFLAG];
  logic [BUS_W-1:0]  lane_d  [MQF_NFLAG];
  logic [BUS_W-1:0]  lane_q  [MQF_NFLAG];

  mqf_cfg_decode #(.NQ_MAX(NQ_MAX), .BUS_W(BUS_W), .CW(CW), .GW(GW)) u_cfg (
    .num_queues (num_queues),
    .cfg_cnt    (cfg_cnt),
    .last_grp   (last_grp),
    .multi_grp  (multi_grp)
  );

  mqf_grp_seq #(.GW(GW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_direct (mode_direct),
    .grp_sel     (grp_sel),
    .multi_grp   (multi_grp),
    .last_grp    (last_grp),
    .grp_nxt     (grp_nxt),
    .grp_q       (grp_id)
  );

  // Flag type k: index 0 excludes the write-port queue, index 1 the read-port queue.
  assign flg_in[MQF_AF]  = af_flags_n;
  assign flg_in[MQF_AE]  = ae_flags_n;
  assign excl_in[MQF_AF] = wr_qsel;
  assign excl_in[MQF_AE] = rd_qsel;

  for (genvar k = 0; k < MQF_NFLAG; k++) begin : g_lane
    mqf_lane_mask #(
      .NQ_MAX(NQ_MAX), .BUS_W(BUS_W), .CW(CW), .GW(GW), .QW(QW)
    ) u_mask (
      .flags_n (flg_in[k]),
      .grp     (grp_nxt),
      .cfg_cnt (cfg_cnt),
      .excl_q  (excl_in[k]),
      .bus_n   (lane_d[k])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lane_q[k] <= '1;
      else        lane_q[k] <= lane_d[k];
    end
  end

  assign af_bus_n = lane_q[MQF_AF];
  assign ae_bus_n = lane_q[MQF_AE];
endmodule

// File: rtl/mqf_flag_bus_chk.sv
module mqf_flag_bus_chk #(
  parameter int unsigned NQ_MAX = 32,
  parameter int unsigned BUS_W  = 8,
  localparam int unsigned NGRP  = NQ_MAX / BUS_W,
  localparam int unsigned GW    = (NGRP > 1) ? $clog2(NGRP) : 1,
  localparam int unsigned CW    = $clog2(NQ_MAX + 1),
  localparam int unsigned QW    = $clog2(NQ_MAX),
  localparam int unsigned LGB   = $clog2(BUS_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CW-1:0]     num_queues,
  input logic              mode_direct,
  input logic [GW-1:0]     grp_sel,
  input logic [QW-1:0]     wr_qsel,
  input logic [QW-1:0]     rd_qsel,
  input logic [BUS_W-1:0]  af_bus_n,
  input logic [BUS_W-1:0]  ae_bus_n,
  input logic [GW-1:0]     grp_id
);
  int cnt_now;
  int last_now;
  int cnt_prev;
  int wr_prev;
  int rd_prev;
  logic [BUS_W-1:0] unconf_m;

  always_comb begin
    cnt_now = int'(num_queues);
    if (cnt_now < 1) cnt_now = 1;
    if (cnt_now > int'(NQ_MAX)) cnt_now = int'(NQ_MAX);
    last_now = (cnt_now - 1) / int'(BUS_W);
  end

  always_ff @(posedge clk) begin
    cnt_prev <= cnt_now;
    wr_prev  <= int'(wr_qsel);
    rd_prev  <= int'(rd_qsel);
  end

  always_comb begin
    for (int i = 0; i < int'(BUS_W); i++)
      unconf_m[i] = (int'(grp_id) * int'(BUS_W) + i) >= cnt_prev;
  end

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (af_bus_n == '1 && ae_bus_n == '1 && grp_id == '0));

  p_single_group_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_now <= int'(BUS_W)) |=> (grp_id == '0));

  p_poll_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_direct && cnt_now > int'(BUS_W) && int'(grp_id) < last_now)
      |=> (grp_id == $past(grp_id) + GW'(1)));

  p_poll_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_direct && cnt_now > int'(BUS_W) && int'(grp_id) >= last_now)
      |=> (grp_id == '0));

  p_direct_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_direct && cnt_now > int'(BUS_W)) |=> (grp_id == $past(grp_sel)));

  p_unconf_af_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (af_bus_n & unconf_m) == unconf_m);

  p_unconf_ae_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ae_bus_n & unconf_m) == unconf_m);

  p_wr_excluded_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_prev >> LGB) == int'(grp_id)) |-> af_bus_n[wr_prev % int'(BUS_W)]);

  p_rd_excluded_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_prev >> LGB) == int'(grp_id)) |-> ae_bus_n[rd_prev % int'(BUS_W)]);
endmodule

bind mqf_flag_bus mqf_flag_bus_chk #(.NQ_MAX(NQ_MAX), .BUS_W(BUS_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .num_queues  (num_queues),
  .mode_direct (mode_direct),
  .grp_sel     (grp_sel),
  .wr_qsel     (wr_qsel),
  .rd_qsel     (rd_qsel),
  .af_bus_n    (af_bus_n),
  .ae_bus_n    (ae_bus_n),
  .grp_id      (grp_id)
);

// File: tb/test_mqf_flag_bus.sv
`timescale 1ns/1ps
module test_mqf_flag_bus;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] af_flags_n = '1;
  logic [31:0] ae_flags_n = '1;
  logic [5:0]  num_queues = 6'd32;
  logic        mode_direct = 1'b0;
  logic [1:0]  grp_sel = '0;
  logic [4:0]  wr_qsel = '0;
  logic [4:0]  rd_qsel = '0;
  logic [7:0]  af_bus_n;
  logic [7:0]  ae_bus_n;
  logic [1:0]  grp_id;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  mqf_flag_bus i_mqf_flag_bus (
    .clk(clk), .rst_n(rst_n), .af_flags_n(af_flags_n), .ae_flags_n(ae_flags_n),
    .num_queues(num_queues), .mode_direct(mode_direct), .grp_sel(grp_sel),
    .wr_qsel(wr_qsel), .rd_qsel(rd_qsel), .af_bus_n(af_bus_n),
    .ae_bus_n(ae_bus_n), .grp_id(grp_id)
  );

  // Behavioural reference model, updated on the same edges as the design.
  int         m_grp;
  logic [7:0] m_af;
  logic [7:0] m_ae;

  always @(posedge clk or negedge rst_n) begin
    int cnt, last, g, q;
    if (!rst_n) begin
      m_grp <= 0;
      m_af  <= 8'hFF;
      m_ae  <= 8'hFF;
    end else begin
      cnt = int'(num_queues);
      if (cnt == 0) cnt = 1;
      if (cnt > 32) cnt = 32;
      last = (cnt - 1) / 8;
      if (cnt <= 8) g = 0;
      else if (mode_direct) g = int'(grp_sel);
      else g = (m_grp >= last) ? 0 : m_grp + 1;
      m_grp <= g;
      for (int i = 0; i < 8; i++) begin
        q = g * 8 + i;
        m_af[i] <= (q < cnt && q != int'(wr_qsel)) ? af_flags_n[q] : 1'b1;
        m_ae[i] <= (q < cnt && q != int'(rd_qsel)) ? ae_flags_n[q] : 1'b1;
      end
    end
  end

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input string tag);
    @(posedge clk);
    @(negedge clk);
    check(tag, "grp_id", int'(grp_id), m_grp);
    check(tag, "af_bus_n", int'(af_bus_n), int'(m_af));
    check(tag, "ae_bus_n", int'(ae_bus_n), int'(m_ae));
  endtask

  task automatic phase(input string tag, input int nq, input bit direct,
                       input int ncyc, input bit all_asserted);
    num_queues  = 6'(nq);
    mode_direct = direct;
    for (int c = 0; c < ncyc; c++) begin
      if (all_asserted) begin
        af_flags_n = '0;
        ae_flags_n = '0;
      end else begin
        af_flags_n = $urandom;
        ae_flags_n = $urandom;
      end
      grp_sel = 2'($urandom);
      wr_qsel = 5'($urandom);
      rd_qsel = 5'($urandom);
      cyc(tag);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    af_flags_n = '0;
    ae_flags_n = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state while held in reset
    check("R1", "af_bus_n reset", int'(af_bus_n), 'hFF);
    check("R1", "ae_bus_n reset", int'(ae_bus_n), 'hFF);
    check("R1", "grp_id reset", int'(grp_id), 0);
    rst_n = 1'b1;
    cyc("R1");

    phase("R2", 5, 1'b0, 40, 1'b0);
    phase("R2", 8, 1'b1, 40, 1'b0);
    phase("R4", 20, 1'b0, 60, 1'b0);
    phase("R4", 12, 1'b0, 40, 1'b0);
    phase("R3", 32, 1'b0, 80, 1'b0);
    phase("R5", 32, 1'b1, 80, 1'b0);
    phase("R5", 17, 1'b1, 60, 1'b0);
    phase("R6", 12, 1'b1, 60, 1'b1);
    phase("R7", 32, 1'b0, 80, 1'b1);
    phase("R7", 32, 1'b1, 80, 1'b1);
    phase("R8", 0, 1'b1, 30, 1'b0);
    phase("R8", 40, 1'b0, 40, 1'b0);

    // R6: direct select of group 3 with 12 queues must show all inactive
    num_queues = 6'd12; mode_direct = 1'b1; grp_sel = 2'd3;
    af_flags_n = '0; ae_flags_n = '0;
    cyc("R6");
    check("R6", "af_bus_n unconfigured group", int'(af_bus_n), 'hFF);
    check("R6", "grp_id unconfigured group", int'(grp_id), 3);

    // R1: reassert reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", "af_bus_n reassert", int'(af_bus_n), 'hFF);
    check("R1", "grp_id reassert", int'(grp_id), 0);
    rst_n = 1'b1;
    cyc("R1");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule